// File: doc/BRIEF.md
# Pilot Common Phase Error Corrector

This block sits after channel equalization in an OFDM receiver and removes the phase rotation that all subcarriers of one symbol share. Equalized subcarriers arrive one per cycle, in ascending index order, on a valid/ready stream. Each complete symbol is written into one of two symbol banks. While the symbol is written, the pilot subcarriers are multiplied by the conjugates of their known values and accumulated. When the symbol is complete, the accumulated complex sum gives one phase estimate. An iterative CORDIC turns that sum into a unit phasor. The buffered symbol is then read back. Only the data subcarriers are emitted, each multiplied by the conjugate of the phasor.

The two banks alternate roles. The next symbol can be written while the previous one is estimated and drained. If both banks still hold symbols, the input ready drops. A correction enable is sampled on the first subcarrier of every symbol. When the enable is low, that symbol's data subcarriers are released bit-exact.

The readout controller has three states. IDLE moves to ESTIMATE when the bank at the read pointer is full, and this move starts the phase unit. ESTIMATE moves to DRAIN when the phase unit reports done. DRAIN moves back to IDLE after the last subcarrier index, and this move frees the bank. The phase unit has five states. P_IDLE goes to P_VEC on start, or straight to P_DONE for an all-zero sum. P_VEC runs the angle iterations, P_LOAD prepares the rotation, P_ROT runs the phasor iterations, and P_DONE returns to P_IDLE.

Top module: `cpe_corrector`

## Requirements
- R1: After reset, in_ready is high and out_valid is low until a symbol has been received.
- R2: A symbol is 128 subcarriers, indices 0 to 127, in ascending order. Indices 6, 16, 26, 38, 48, 58, 70, 80, 90, 102, 112 and 122 are pilots and are never emitted. The 116 data subcarriers of each symbol come out in ascending index order, one out_valid pulse each.
- R3: The pilot value expected at indices 38, 90 and 112 is -1, and at every other pilot index it is +1. The symbol's phase is the angle θ of the sum of each received pilot times its expected value. When correction is enabled, each data subcarriers d leaves as d·e^(-jθ), within ±6 LSB per component.
- R4: Every symbol gets its own estimate. Consecutive symbols with different rotations are each corrected by their own angle.
- R5: corr_en is sampled with subcarrier 0 of a symbol. If it is low, that symbol's data subcarriers leave unchanged, bit-exact.
- R6: in_ready is low only while both banks hold unread symbols. No subcarrier is lost or reordered under back-pressure, and the write position holds while ready is low.
- R7: If the pilot sum of a symbol is exactly zero, the phase is taken as zero and the data leave bit-exact.
- R8: Rotations close to +π and -π are estimated and corrected to the accuracy of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| corr_en | input | 1 | Phase correction enable, sampled with subcarrier 0 |
| in_valid | input | 1 | Input subcarrier valid |
| in_re | input | W | Input real part, signed |
| in_im | input | W | Input imaginary part, signed |
| in_ready | output | 1 | Input can be accepted |
| out_valid | output | 1 | Output data subcarrier valid |
| out_re | output | W | Corrected real part, signed |
| out_im | output | W | Corrected imaginary part, signed |

## Verification
The hardest condition to reach from the ports is the one where both banks are occupied. In that case ready falls in the middle of a symbol, while the other bank is still being estimated or drained. The stimulus streams three symbols back to back with no idle gap. Reading a symbol out costs about thirty cycles more than writing one, so the writer catches up with the reader and must stall. During that stretch the enable is also changed from symbol to symbol, so the per-bank enable latch is exercised while writing and reading overlap. Separate symbols place the rotation near ±π and drive the pilots to exactly zero.

// File: rtl/cpe_pkg.sv
package cpe_pkg;

    typedef enum logic [1:0] {RD_IDLE, RD_EST, RD_DRAIN} rd_state_t;

    typedef enum logic [2:0] {P_IDLE, P_VEC, P_LOAD, P_ROT, P_DONE} ph_state_t;

    // Angle of atan(2^-i); a full turn is 2^16 units
    function automatic logic signed [15:0] atan_step(input logic [4:0] i);
        case (i)
            5'd0:    return 16'sd8192;
            5'd1:    return 16'sd4836;
            5'd2:    return 16'sd2555;
            5'd3:    return 16'sd1297;
            5'd4:    return 16'sd651;
            5'd5:    return 16'sd326;
            5'd6:    return 16'sd163;
            5'd7:    return 16'sd81;
            5'd8:    return 16'sd41;
            5'd9:    return 16'sd20;
            5'd10:   return 16'sd10;
            5'd11:   return 16'sd5;
            5'd12:   return 16'sd3;
            5'd13:   return 16'sd1;
            5'd14:   return 16'sd1;
            default: return 16'sd0;
        endcase
    endfunction

endpackage

// File: rtl/cpe_sym_buf.sv
module cpe_sym_buf #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/cpe_phase_unit.sv
module cpe_phase_unit #(
    parameter int W    = 16,
    parameter int SW   = 23,
    parameter int ITER = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic signed [SW-1:0] sum_re,
    input  logic signed [SW-1:0] sum_im,
    output logic                 done,
    output logic signed [W-1:0]  ph_c,
    output logic signed [W-1:0]  ph_s
);
    import cpe_pkg::*;

    localparam int CW   = SW + 2;
    localparam int FRAC = W - 2;
    localparam int ONE  = 1 << FRAC;
    localparam logic signed [CW-1:0] KINV =
        CW'((longint'(ONE) * 64'sd6072529) / 64'sd10000000);
    localparam logic [4:0] LAST = 5'(ITER - 1);

    ph_state_t pstate, pnext;
    logic signed [CW-1:0] x, y;
    logic signed [15:0]   z;
    logic [4:0]           it;
    logic                 sum_zero;
    logic signed [15:0]   step;

    assign sum_zero = (sum_re == '0) && (sum_im == '0);
    assign step     = atan_step(it);
    assign done     = (pstate == P_DONE);

    always_ff @(posedge clk) begin
        if (rst) pstate <= P_IDLE;
        else     pstate <= pnext;
    end

    always_comb begin
        pnext = pstate;
        unique case (pstate)
            P_IDLE: if (start) pnext = sum_zero ? P_DONE : P_VEC;
            P_VEC:  if (it == LAST) pnext = P_LOAD;
            P_LOAD: pnext = P_ROT;
            P_ROT:  if (it == LAST) pnext = P_DONE;
            P_DONE: pnext = P_IDLE;
            default: pnext = P_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x <= '0; y <= '0; z <= '0; it <= '0;
            ph_c <= W'(ONE); ph_s <= '0;
        end else begin
            unique case (pstate)
                P_IDLE: if (start) begin
                    it <= '0;
                    z  <= '0;
                    if (sum_zero) begin
                        x <= CW'(ONE); y <= '0;
                    end else if (sum_re[SW-1]) begin
                        x <= -{{2{sum_re[SW-1]}}, sum_re};
                        y <= -{{2{sum_im[SW-1]}}, sum_im};
                        z <= 16'sh8000;
                    end else begin
                        x <= {{2{sum_re[SW-1]}}, sum_re};
                        y <= {{2{sum_im[SW-1]}}, sum_im};
                    end
                end
                P_VEC: begin
                    if (!y[CW-1]) begin
                        x <= x + (y >>> it); y <= y - (x >>> it); z <= z + step;
                    end else begin
                        x <= x - (y >>> it); y <= y + (x >>> it); z <= z - step;
                    end
                    it <= (it == LAST) ? 5'd0 : it + 5'd1;
                end
                P_LOAD: begin
                    y <= '0;
                    if (z[15] != z[14]) begin
                        x <= -KINV; z <= z + 16'sh8000;
                    end else begin
                        x <= KINV;
                    end
                end
                P_ROT: begin
                    if (!z[15]) begin
                        x <= x - (y >>> it); y <= y + (x >>> it); z <= z - step;
                    end else begin
                        x <= x + (y >>> it); y <= y - (x >>> it); z <= z + step;
                    end
                    it <= (it == LAST) ? 5'd0 : it + 5'd1;
                end
                P_DONE: begin
                    ph_c <= x[W-1:0];
                    ph_s <= y[W-1:0];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cpe_derotator.sv
module cpe_derotator #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                vin,
    input  logic [2*W-1:0]      din,
    input  logic signed [W-1:0] c,
    input  logic signed [W-1:0] s,
    output logic                vout,
    output logic signed [W-1:0] q_re,
    output logic signed [W-1:0] q_im
);
    localparam int FRAC = W - 2;

    logic signed [W-1:0] dr, di;
    logic signed [2*W:0] pr, pi;

    assign dr = din[2*W-1:W];
    assign di = din[W-1:0];
    assign pr = dr * c + di * s;
    assign pi = di * c - dr * s;

    always_ff @(posedge clk) begin
        if (rst) begin
            vout <= 1'b0; q_re <= '0; q_im <= '0;
        end else begin
            vout <= vin;
            if (vin) begin
                q_re <= pr[FRAC+W-1:FRAC];
                q_im <= pi[FRAC+W-1:FRAC];
            end
        end
    end
endmodule

// File: rtl/cpe_corrector.sv
module cpe_corrector #(
    parameter int W    = 16,
    parameter int NSC  = 128,
    parameter int ITER = 14,
    parameter logic [NSC-1:0] PILOT_MASK =
        (128'(1) << 6)  | (128'(1) << 16) | (128'(1) << 26) | (128'(1) << 38) |
        (128'(1) << 48) | (128'(1) << 58) | (128'(1) << 70) | (128'(1) << 80) |
        (128'(1) << 90) | (128'(1) << 102) | (128'(1) << 112) | (128'(1) << 122),
    parameter logic [NSC-1:0] PILOT_NEG =
        (128'(1) << 38) | (128'(1) << 90) | (128'(1) << 112)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                corr_en,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_re,
    input  logic signed [W-1:0] in_im,
    output logic                in_ready,
    output logic                out_valid,
    output logic signed [W-1:0] out_re,
    output logic signed [W-1:0] out_im
);
    import cpe_pkg::*;

    localparam int IW   = $clog2(NSC);
    localparam int SW   = W + IW;
    localparam int DW   = 2 * W;
    localparam int ONE  = 1 << (W - 2);
    localparam logic [IW-1:0] LAST_IDX = IW'(NSC - 1);

    // write side
    logic                 wr_bank;
    logic [IW-1:0]        wr_idx;
    logic signed [SW-1:0] acc_re, acc_im;
    logic signed [SW-1:0] sum_re [2];
    logic signed [SW-1:0] sum_im [2];
    logic                 bank_en [2];
    logic [1:0]           bank_full;
    logic                 accept, wr_last;
    logic signed [SW-1:0] ext_re, ext_im, add_re, add_im, nxt_re, nxt_im;

    // read side
    rd_state_t            rstate, rnext;
    logic                 rd_bank;
    logic [IW-1:0]        rd_idx;
    logic                 cur_en, est_start, est_done, release_bank, drain_active;
    logic                 keep_q;
    logic [DW-1:0]        rd_word;
    logic signed [W-1:0]  ph_c, ph_s, use_c, use_s;

    assign in_ready = !bank_full[wr_bank];
    assign accept   = in_valid && in_ready;
    assign wr_last  = (wr_idx == LAST_IDX);

    assign ext_re = SW'(in_re);
    assign ext_im = SW'(in_im);
    assign add_re = !PILOT_MASK[wr_idx] ? '0 : (PILOT_NEG[wr_idx] ? -ext_re : ext_re);
    assign add_im = !PILOT_MASK[wr_idx] ? '0 : (PILOT_NEG[wr_idx] ? -ext_im : ext_im);
    assign nxt_re = ((wr_idx == '0) ? '0 : acc_re) + add_re;
    assign nxt_im = ((wr_idx == '0) ? '0 : acc_im) + add_im;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_bank <= 1'b0; wr_idx <= '0;
            acc_re <= '0; acc_im <= '0;
            for (int b = 0; b < 2; b++) begin
                sum_re[b] <= '0; sum_im[b] <= '0; bank_en[b] <= 1'b0;
            end
        end else if (accept) begin
            if (wr_idx == '0) bank_en[wr_bank] <= corr_en;
            acc_re <= nxt_re;
            acc_im <= nxt_im;
            if (wr_last) begin
                sum_re[wr_bank] <= nxt_re;
                sum_im[wr_bank] <= nxt_im;
                wr_idx  <= '0;
                wr_bank <= ~wr_bank;
            end else begin
                wr_idx <= wr_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bank_full <= '0;
        else begin
            for (int b = 0; b < 2; b++) begin
                if (accept && wr_last && (wr_bank == 1'(b)))
                    bank_full[b] <= 1'b1;
                else if (release_bank && (rd_bank == 1'(b)))
                    bank_full[b] <= 1'b0;
            end
        end
    end

    // readout controller: state register
    always_ff @(posedge clk) begin
        if (rst) rstate <= RD_IDLE;
        else     rstate <= rnext;
    end

    // readout controller: next state and outputs
    always_comb begin
        rnext        = rstate;
        est_start    = 1'b0;
        release_bank = 1'b0;
        unique case (rstate)
            RD_IDLE:  if (bank_full[rd_bank]) begin
                          est_start = 1'b1;
                          rnext     = RD_EST;
                      end
            RD_EST:   if (est_done) rnext = RD_DRAIN;
            RD_DRAIN: if (rd_idx == LAST_IDX) begin
                          release_bank = 1'b1;
                          rnext        = RD_IDLE;
                      end
            default:  rnext = RD_IDLE;
        endcase
    end

    assign drain_active = (rstate == RD_DRAIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_idx <= '0; rd_bank <= 1'b0; cur_en <= 1'b0; keep_q <= 1'b0;
        end else begin
            keep_q <= drain_active && !PILOT_MASK[rd_idx];
            if (est_start) cur_en <= bank_en[rd_bank];
            if (drain_active) rd_idx <= release_bank ? '0 : rd_idx + 1'b1;
            if (release_bank) rd_bank <= ~rd_bank;
        end
    end

    cpe_sym_buf #(.DW(DW), .AW(IW + 1)) u_buf (
        .clk     (clk),
        .wr_en   (accept),
        .wr_addr ({wr_bank, wr_idx}),
        .wr_data ({in_re, in_im}),
        .rd_addr ({rd_bank, rd_idx}),
        .rd_data (rd_word)
    );

    cpe_phase_unit #(.W(W), .SW(SW), .ITER(ITER)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .start  (est_start),
        .sum_re (sum_re[rd_bank]),
        .sum_im (sum_im[rd_bank]),
        .done   (est_done),
        .ph_c   (ph_c),
        .ph_s   (ph_s)
    );

    assign use_c = cur_en ? ph_c : W'(ONE);
    assign use_s = cur_en ? ph_s : '0;

    cpe_derotator #(.W(W)) u_rot (
        .clk  (clk),
        .rst  (rst),
        .vin  (keep_q),
        .din  (rd_word),
        .c    (use_c),
        .s    (use_s),
        .vout (out_valid),
        .q_re (out_re),
        .q_im (out_im)
    );
endmodule

// File: rtl/cpe_corrector_checks.sv
module cpe_corrector_checks #(
    parameter int W  = 16,
    parameter int IW = 7
) (
    input logic                clk,
    input logic                rst,
    input logic                in_ready,
    input logic                out_valid,
    input logic [1:0]          bank_full,
    input logic [IW-1:0]       wr_idx,
    input logic                drain_active,
    input logic signed [W-1:0] ph_c,
    input logic signed [W-1:0] ph_s
);
    localparam longint ONE = longint'(1) << (W - 2);
    localparam longint LO  = (ONE * ONE / 100) * 97;
    localparam longint HI  = (ONE * ONE / 100) * 103;

    longint mag2;
    assign mag2 = longint'(ph_c) * longint'(ph_c) + longint'(ph_s) * longint'(ph_s);

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (in_ready && !out_valid));

    assert_blocked_only_when_full_R6: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> (bank_full == 2'b11));

    assert_stall_holds_position_R6: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> $stable(wr_idx));

    assert_output_follows_drain_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(drain_active, 2));

    assert_unit_phasor_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(drain_active) |-> (mag2 >= LO && mag2 <= HI));
endmodule

bind cpe_corrector cpe_corrector_checks #(.W(W), .IW(IW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .bank_full    (bank_full),
    .wr_idx       (wr_idx),
    .drain_active (drain_active),
    .ph_c         (ph_c),
    .ph_s         (ph_s)
);

// File: tb/sim_cpe_corrector.sv
`timescale 1ns/1ps
module sim_cpe_corrector;
    localparam int W   = 16;
    localparam int NSC = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic corr_en = 1'b0;
    logic in_valid = 1'b0;
    logic signed [W-1:0] in_re = '0, in_im = '0;
    logic in_ready, out_valid;
    logic signed [W-1:0] out_re, out_im;

    always #2.5 clk = ~clk;

    cpe_corrector u0 (
        .clk(clk), .rst(rst), .corr_en(corr_en), .in_valid(in_valid),
        .in_re(in_re), .in_im(in_im), .in_ready(in_ready),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    typedef struct { int re; int im; bit exact; int req; } exp_t;
    exp_t sb[$];

    int checks = 0, fails = 0, outs = 0, pushed = 0, stalls = 0;
    int seed = 12345;
    bit finished = 1'b0;

    int pil_idx [12] = '{6, 16, 26, 38, 48, 58, 70, 80, 90, 102, 112, 122};

    function automatic bit is_pilot(int k);
        foreach (pil_idx[i]) if (pil_idx[i] == k) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int pil_sign(int k);
        return (k == 38 || k == 90 || k == 112) ? -1 : 1;
    endfunction

    function automatic int rnd(real v);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    function automatic int next_val();
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        return ((seed >>> 8) % 10001) - 5000;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // driver: builds one symbol, pushes expected data subcarriers, streams it
    task automatic send_symbol(real th, real pamp, bit en, int req);
        int rr [NSC];
        int ri [NSC];
        real sr, si, te, ce, se;
        sr = 0.0; si = 0.0;
        for (int k = 0; k < NSC; k++) begin
            if (is_pilot(k)) begin
                rr[k] = pil_sign(k) * rnd(pamp * $cos(th));
                ri[k] = pil_sign(k) * rnd(pamp * $sin(th));
                sr += pil_sign(k) * rr[k];
                si += pil_sign(k) * ri[k];
            end else begin
                int br, bi;
                br = next_val(); bi = next_val();
                rr[k] = rnd(br * $cos(th) - bi * $sin(th));
                ri[k] = rnd(br * $sin(th) + bi * $cos(th));
            end
        end
        te = (sr == 0.0 && si == 0.0) ? 0.0 : $atan2(si, sr);
        ce = $cos(te); se = $sin(te);
        for (int k = 0; k < NSC; k++) begin
            if (!is_pilot(k)) begin
                exp_t e;
                e.req = req;
                if (!en || pamp == 0.0) begin
                    e.re = rr[k]; e.im = ri[k]; e.exact = 1'b1;
                end else begin
                    e.re = rnd(rr[k] * ce + ri[k] * se);
                    e.im = rnd(ri[k] * ce - rr[k] * se);
                    e.exact = 1'b0;
                end
                sb.push_back(e);
                pushed++;
            end
        end
        for (int k = 0; k < NSC; k++) begin
            @(negedge clk);
            in_valid = 1'b1; corr_en = en;
            in_re = W'(rr[k]); in_im = W'(ri[k]);
            while (!in_ready) begin
                stalls++;
                @(negedge clk);
            end
        end
    endtask

    task automatic idle(int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops and compares each emitted subcarrier
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            outs++;
            if (sb.size() == 0) begin
                check(1'b0, "R2 unexpected output", int'(out_re), 0);
            end else begin
                exp_t e;
                int tol, dre, dim;
                e = sb.pop_front();
                tol = e.exact ? 0 : 6;
                dre = int'(out_re) - e.re; if (dre < 0) dre = -dre;
                dim = int'(out_im) - e.im; if (dim < 0) dim = -dim;
                if (dre > tol || dim > tol)
                    $display("FAIL R%0d re/im actual=%0d/%0d expected=%0d/%0d",
                             e.req, out_re, out_im, e.re, e.im);
                checks++;
                if (dre > tol || dim > tol) fails++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", outs, pushed);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);

        send_symbol(0.5, 3000.0, 1'b1, 3);   // R3 basic rotation
        idle(40);
        send_symbol(-2.5, 3000.0, 1'b1, 4);  // R4 new angle, left half-plane
        idle(40);
        send_symbol(2.0, 3000.0, 1'b0, 5);   // R5 bypass, exact
        idle(40);
        send_symbol(3.1, 3000.0, 1'b1, 8);   // R8 near +pi
        idle(40);
        send_symbol(-3.1, 3000.0, 1'b1, 8);  // R8 near -pi
        idle(40);
        send_symbol(1.2, 0.0, 1'b1, 7);      // R7 zero pilot sum
        idle(40);
        stalls = 0;
        send_symbol(1.0, 3000.0, 1'b1, 6);   // R6 back-to-back stream
        send_symbol(-1.0, 3000.0, 1'b0, 6);
        send_symbol(0.2, 2500.0, 1'b1, 6);
        idle(10);
        check(stalls > 0, "R6 ready never dropped under back-to-back input", stalls, 1);

        for (int t = 0; t < 2000 && sb.size() != 0; t++) @(negedge clk);
        repeat (20) @(negedge clk);
        check(sb.size() == 0, "R2 missing outputs", sb.size(), 0);
        check(outs == 9 * 116, "R2 data subcarrier count", outs, 9 * 116);
        check(in_ready == 1'b1, "R6 ready after drain", int'(in_ready), 1);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule